// File: doc/BRIEF.md
# Gate Driver Protection and Fault Supervisor

This block sits between the shutdown sense inputs of a three-phase gate driver and its six output stages. It watches an overcurrent trip comparator, an enable input, and undervoltage flags for the low-side supply and the high-side supply. From these it produces three outputs:

- a force-off for every output stage;
- a separate force-off for the high-side stages only;
- an active-low fault indication paired with an output-enable, so that an external pull-up can model an open-drain line.

Each shutdown cause follows its own rule.

- **Trip:** the trip comparator is blanked for `BLANK_CYC` cycles and then latched by a four-state machine.
  - In auto mode, a trip fault is released after a clear delay of `CLR_CYC` cycles, counted once the trip input has returned low.
  - In latched mode, it is released only by an explicit user clear.
- **Low-side undervoltage:** forces every stage off and raises the fault, but is not latched.
- **High-side undervoltage:** turns off only the high-side stages and leaves the fault released.
- **Low enable:** turns off every stage without raising the fault.

The machine has four states. `ST_RUN` is the normal state. `ST_TRIPPED` means the trip is latched and the comparator is still high. `ST_COUNTDOWN` means the trip is low and the clear timer is running. `ST_HOLD` means the trip is low in latched mode and the block is waiting for a user clear. Its transitions are:

- **RUN→TRIPPED:** a blanked-valid trip.
- **TRIPPED→COUNTDOWN:** the trip returns low with the mode input low.
- **TRIPPED→HOLD:** the trip returns low with the mode input high.
- **COUNTDOWN→TRIPPED:** a new valid trip, which restarts the timer.
- **COUNTDOWN→RUN:** the timer expires, or a user clear arrives while the trip is low.
- **COUNTDOWN→HOLD:** the mode input rises.
- **HOLD→TRIPPED:** a new valid trip.
- **HOLD→RUN:** a user clear arrives while the trip is low.
- **HOLD→COUNTDOWN:** the mode input falls, which starts a fresh delay.

Top module: `gate_prot_supervisor`

## Requirements
- R1: After reset, with enable high and no undervoltage, `kill_all_o`=0, `kill_hi_o`=0, `fault_n_o`=1 and `fault_oe_o`=0.
- R2: A trip input that is high for fewer than `BLANK_CYC` consecutive rising edges has no effect on any output (`BLANK_CYC` is at least 2).
- R3: A trip input that is high on `BLANK_CYC` consecutive rising edges asserts `kill_all_o`, `kill_hi_o` and the fault after the next rising edge, and not before it.
- R4: While the trip input stays high, a latched trip fault is held, and a user clear has no effect.
- R5: In auto mode (`latch_mode_i`=0), the trip fault is still asserted after `CLR_CYC`+1 rising edges that sample the trip low, and it is released after the next edge.
- R6: A valid trip during the clear countdown restarts it, so the full `CLR_CYC`+2 edge window applies again from the second release.
- R7: In latched mode (`latch_mode_i`=1), the trip fault is never released by the delay. It is released by the rising edge that samples `user_clr_i` high while the trip is low. A clear with the trip high is ignored.
- R8: In auto mode, a user clear during the countdown releases the fault at the next rising edge.
- R9: Low-side undervoltage asserts `kill_all_o`, `kill_hi_o` and the fault in the same cycle, without a clock edge. The fault is released as soon as the flag drops, with no latching.
- R10: High-side undervoltage alone asserts `kill_hi_o` only; `kill_all_o` and the fault stay released.
- R11: A low enable asserts `kill_all_o` and `kill_hi_o` while the fault stays released.
- R12: The fault is signalled as `fault_n_o`=0 with `fault_oe_o`=1. When there is no fault, `fault_n_o`=1 and `fault_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Overcurrent comparator output, synchronous, high = overload |
| enable_i | input | 1 | Driver enable, low forces all stages off |
| uv_lo_i | input | 1 | Low-side supply undervoltage flag |
| uv_hi_i | input | 1 | High-side supply undervoltage flag |
| latch_mode_i | input | 1 | 1 = trip fault cleared only by user clear, 0 = cleared after delay |
| user_clr_i | input | 1 | User clear of a trip fault |
| kill_all_o | output | 1 | Force all six driver outputs off |
| kill_hi_o | output | 1 | Force the three high-side driver outputs off |
| fault_n_o | output | 1 | Fault indication, active low |
| fault_oe_o | output | 1 | Drive enable for fault_n_o (open-drain model) |

## Verification
The bench targets several edge-exact boundaries:

- **Blanking:** a pulse one edge short of the blanking window must not trip. A design with an off-by-one counter would either shut down on that pulse or shut down one cycle late.
- **Clear delay:** the fault is sampled on the last edge before release and on the edge of release. A timer that starts counting while the trip is still high, or that does not saturate, fails one of the two samples.
- **Countdown restart:** a trip landing mid-countdown must restart the delay. A design that keeps counting releases early and is caught at the last held edge.
- **Clear handling and cause separation:** in latched mode the delay must never release the fault, and a user clear with the trip still high must be ignored. The undervoltage and enable combinations are swept to catch a high-side flag or a low enable that wrongly raises the fault, or a low-side flag that latches.

// File: rtl/gps_pkg.sv
package gps_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_TRIPPED   = 2'd1,
        ST_COUNTDOWN = 2'd2,
        ST_HOLD      = 2'd3
    } sup_state_e;

endpackage

// File: rtl/gps_trip_blanker.sv
module gps_trip_blanker #(
    parameter int unsigned BLANK_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    output logic trip_valid_o
);

    generate
        if (BLANK_CYC == 0) begin : g_noblank
            assign trip_valid_o = trip_i;
        end else begin : g_blank
            localparam int unsigned CW = $clog2(BLANK_CYC + 1);
            localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYC);

            logic [CW-1:0] run_q;

            // Count consecutive high samples, saturating at the window length.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    run_q <= '0;
                end else if (!trip_i) begin
                    run_q <= '0;
                end else if (run_q != LIMIT) begin
                    run_q <= run_q + 1'b1;
                end
            end

            assign trip_valid_o = (run_q == LIMIT);
        end
    endgenerate

endmodule

// File: rtl/gps_clear_timer.sv
module gps_clear_timer #(
    parameter int unsigned CLR_CYC = 165000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic done_o
);

    localparam int unsigned TW = $clog2(CLR_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(CLR_CYC);

    logic [TW-1:0] cnt_q;

    // Held at zero outside the countdown; runs up and saturates once inside it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LIMIT);

endmodule

// File: rtl/gate_prot_supervisor.sv
module gate_prot_supervisor
    import gps_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 13,
    parameter int unsigned CLR_CYC   = 165000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic enable_i,
    input  logic uv_lo_i,
    input  logic uv_hi_i,
    input  logic latch_mode_i,
    input  logic user_clr_i,
    output logic kill_all_o,
    output logic kill_hi_o,
    output logic fault_n_o,
    output logic fault_oe_o
);

    sup_state_e state_q;
    sup_state_e state_d;
    logic       trip_valid;
    logic       tmr_done;
    logic       tmr_hold;
    logic       clr_ok;
    logic       fault;

    gps_trip_blanker #(
        .BLANK_CYC (BLANK_CYC)
    ) u_blank (
        .clk          (clk),
        .rst_n        (rst_n),
        .trip_i       (trip_i),
        .trip_valid_o (trip_valid)
    );

    assign tmr_hold = (state_q != ST_COUNTDOWN);

    gps_clear_timer #(
        .CLR_CYC (CLR_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (tmr_hold),
        .done_o (tmr_done)
    );

    assign clr_ok = user_clr_i && !trip_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (trip_valid) state_d = ST_TRIPPED;
            end
            ST_TRIPPED: begin
                if (!trip_i) state_d = latch_mode_i ? ST_HOLD : ST_COUNTDOWN;
            end
            ST_COUNTDOWN: begin
                if (trip_valid)        state_d = ST_TRIPPED;
                else if (clr_ok)       state_d = ST_RUN;
                else if (latch_mode_i) state_d = ST_HOLD;
                else if (tmr_done)     state_d = ST_RUN;
            end
            ST_HOLD: begin
                if (trip_valid)         state_d = ST_TRIPPED;
                else if (clr_ok)        state_d = ST_RUN;
                else if (!latch_mode_i) state_d = ST_COUNTDOWN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs: trip fault and low-side undervoltage raise the fault;
    // enable and high-side undervoltage only add shutdown terms.
    always_comb begin
        fault      = (state_q != ST_RUN) || uv_lo_i;
        kill_all_o = fault || !enable_i;
        kill_hi_o  = kill_all_o || uv_hi_i;
        fault_n_o  = !fault;
        fault_oe_o = fault;
    end

endmodule

// File: rtl/gps_checker.sv
module gps_checker
    import gps_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       trip_i,
    input logic       enable_i,
    input logic       uv_lo_i,
    input logic       uv_hi_i,
    input logic       latch_mode_i,
    input logic       user_clr_i,
    input logic       kill_all_o,
    input logic       kill_hi_o,
    input logic       fault_n_o,
    input logic       fault_oe_o,
    input sup_state_e st,
    input logic       tmr_done
);

    // R2: a fresh trip edge cannot latch on the following clock
    p_blank_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trip_i) && st == ST_RUN) |=> (st == ST_RUN));

    // R4: latched trip is held while the comparator stays high
    p_hold_while_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_RUN && trip_i) |=> (st != ST_RUN));

    // R5: countdown cannot release before the timer expires without a clear
    p_no_early_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNTDOWN && !user_clr_i && !tmr_done) |=> (st != ST_RUN));

    // R7: latched mode never releases without a user clear
    p_latched_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && latch_mode_i && !user_clr_i) |=> (st != ST_RUN));

    // R9: low-side undervoltage shuts everything and flags
    p_uvlo_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lo_i |-> (!fault_n_o && kill_all_o && kill_hi_o));

    // R10: high-side undervoltage alone touches only the high side
    p_hi_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_hi_i && enable_i && !uv_lo_i && st == ST_RUN)
            |-> (kill_hi_o && !kill_all_o && fault_n_o));

    // R11: low enable shuts outputs silently
    p_enable_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !uv_lo_i && st == ST_RUN) |-> (kill_all_o && fault_n_o));

    // R12: fault line is driven exactly when it is low
    p_od_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_oe_o != fault_n_o));

    // R10: a full shutdown always includes the high side
    p_kill_nesting_r10: assert property (@(posedge clk) disable iff (!rst_n)
        kill_all_o |-> kill_hi_o);

endmodule

bind gate_prot_supervisor gps_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_i       (trip_i),
    .enable_i     (enable_i),
    .uv_lo_i      (uv_lo_i),
    .uv_hi_i      (uv_hi_i),
    .latch_mode_i (latch_mode_i),
    .user_clr_i   (user_clr_i),
    .kill_all_o   (kill_all_o),
    .kill_hi_o    (kill_hi_o),
    .fault_n_o    (fault_n_o),
    .fault_oe_o   (fault_oe_o),
    .st           (state_q),
    .tmr_done     (tmr_done)
);

// File: tb/gate_prot_supervisor_tb.sv
`timescale 1ns/1ps
module gate_prot_supervisor_tb;

    localparam int unsigned BLANK = 4;
    localparam int unsigned CLR   = 40;

    // {kill_all, kill_hi, fault_n, fault_oe}
    localparam logic [3:0] O_OK   = 4'b0010;
    localparam logic [3:0] O_TRIP = 4'b1101;

    // {enable, uv_lo, uv_hi, kill_all, kill_hi, fault_n, fault_oe}
    localparam logic [6:0] VEC [8] = '{
        7'b000_1110, 7'b001_1110, 7'b010_1101, 7'b011_1101,
        7'b100_0010, 7'b101_0110, 7'b110_1101, 7'b111_1101
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trip_i = 1'b0;
    logic enable_i = 1'b1;
    logic uv_lo_i = 1'b0;
    logic uv_hi_i = 1'b0;
    logic latch_mode_i = 1'b0;
    logic user_clr_i = 1'b0;
    logic kill_all_o, kill_hi_o, fault_n_o, fault_oe_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gate_prot_supervisor #(
        .BLANK_CYC (BLANK),
        .CLR_CYC   (CLR)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trip_i       (trip_i),
        .enable_i     (enable_i),
        .uv_lo_i      (uv_lo_i),
        .uv_hi_i      (uv_hi_i),
        .latch_mode_i (latch_mode_i),
        .user_clr_i   (user_clr_i),
        .kill_all_o   (kill_all_o),
        .kill_hi_o    (kill_hi_o),
        .fault_n_o    (fault_n_o),
        .fault_oe_o   (fault_oe_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {kill_all_o, kill_hi_o, fault_n_o, fault_oe_o};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic trip_latch();
        trip_i = 1'b1;
        tick(BLANK + 1);
        trip_i = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset", O_OK);

        // Level combinations in idle state
        for (int i = 0; i < 8; i++) begin
            string tag;
            {enable_i, uv_lo_i, uv_hi_i} = VEC[i][6:4];
            tick(1);
            if (uv_lo_i)        tag = "R9 vec";
            else if (!enable_i) tag = "R11 vec";
            else if (uv_hi_i)   tag = "R10 vec";
            else                tag = "R12 vec";
            chk(tag, VEC[i][3:0]);
        end
        {enable_i, uv_lo_i, uv_hi_i} = 3'b100;
        tick(1);

        // R2: pulse one edge short of blanking
        trip_i = 1'b1;
        tick(BLANK - 1);
        trip_i = 1'b0;
        chk("R2 short pulse", O_OK);
        tick(5);
        chk("R2 after pulse", O_OK);

        // R3: exact blanking boundary
        trip_i = 1'b1;
        tick(BLANK);
        chk("R3 before latch", O_OK);
        tick(1);
        chk("R3 latched", O_TRIP);

        // R4: held while high, clear ignored
        tick(10);
        user_clr_i = 1'b1;
        tick(2);
        user_clr_i = 1'b0;
        chk("R4 held with clear", O_TRIP);

        // R5: auto clear delay boundary
        trip_i = 1'b0;
        tick(CLR + 1);
        chk("R5 last held edge", O_TRIP);
        tick(1);
        chk("R5 released", O_OK);

        // R6: retrigger restarts countdown
        trip_latch();
        tick(20);
        chk("R6 mid countdown", O_TRIP);
        trip_latch();
        tick(CLR + 1);
        chk("R6 restarted hold", O_TRIP);
        tick(1);
        chk("R6 released", O_OK);

        // R8: user clear during countdown
        trip_latch();
        tick(5);
        user_clr_i = 1'b1;
        tick(1);
        user_clr_i = 1'b0;
        chk("R8 early clear", O_OK);

        // R7: latched mode
        latch_mode_i = 1'b1;
        trip_latch();
        tick(CLR + 10);
        chk("R7 no delay release", O_TRIP);
        user_clr_i = 1'b1;
        tick(1);
        user_clr_i = 1'b0;
        chk("R7 user clear", O_OK);

        trip_i = 1'b1;
        tick(BLANK + 1);
        user_clr_i = 1'b1;
        tick(1);
        user_clr_i = 1'b0;
        chk("R7 clear with trip high", O_TRIP);
        trip_i = 1'b0;
        tick(1);
        chk("R7 hold", O_TRIP);
        user_clr_i = 1'b1;
        tick(1);
        user_clr_i = 1'b0;
        chk("R7 second clear", O_OK);
        latch_mode_i = 1'b0;

        // R9: not latched
        uv_lo_i = 1'b1;
        tick(1);
        chk("R9 uv low", O_TRIP);
        uv_lo_i = 1'b0;
        tick(1);
        chk("R9 recovered", O_OK);

        // R10 / R11 while idle, then back
        uv_hi_i = 1'b1;
        tick(3);
        chk("R10 hi only", 4'b0110);
        uv_hi_i = 1'b0;
        enable_i = 1'b0;
        tick(3);
        chk("R11 disabled", 4'b1110);
        enable_i = 1'b1;
        tick(1);
        chk("R11 re-enabled", O_OK);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule